// File: doc/BRIEF.md
# Oversampled Asynchronous DAC Word Receiver

This block takes a 16-bit converter code delivered as a single asynchronous frame on one serial line. The line rests high. A frame opens with a low start bit, carries sixteen data bits with the most significant bit first, and closes with a high stop bit. The receiver clock runs at sixteen times the bit rate, so every bit cell lasts sixteen clocks. The receiver does not recover a clock. It counts clocks from the start edge and samples each cell at fixed offsets from that edge.

A frame with a good stop bit copies the received code into the holding register that feeds the converter, and a one-clock strobe marks the update. If the stop bit reads low, the receiver drops the frame. The holding register keeps its old value, and a one-clock error pulse appears instead. A mode input enables the receiver. While it is low, the receiver stays idle and ignores the line.

Top module: `async_word_rx`

## Requirements
- R1: While reset is held and after it is released, `dac_word` is 0 and `word_valid` and `frame_err` are low.
- R2: Each bit cell is 16 clocks long. Bit k (k = 0 for the first data bit after the start bit) is stored in `dac_word[15-k]`, so the first data bit becomes the most significant bit.
- R3: `word_valid` is high for exactly one clock, in the cycle where `dac_word` first shows the new code. `dac_word` changes in no other cycle.
- R4: If the stop bit is sampled low, `frame_err` is high for exactly one clock, in the cycle after the stop sample. `word_valid` stays low and `dac_word` keeps its previous value.
- R5: If the synchronised line is high again at count 8, the centre of the start cell, the receiver treats the start as a glitch. It goes back to waiting for a falling edge and produces no strobe or error.
- R6: After any frame, good or bad, the receiver re-arms only once the line has been seen high. A line that stays low after the stop sample starts no new frame.
- R7: While `latch_hi` is low, the receiver is idle. Activity on the line causes no strobe, no error and no change of `dac_word`.
- R8: `serial_in` passes through a two-flop synchronizer. Count 0 is the clock after the synchronised falling edge. The start bit is checked at count 8, data bit k at count 24+16k, and the stop bit at count 280. Take the first rising edge that sees `serial_in` low as edge 1. Then `word_valid` or `frame_err` is visible just after edge 284.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| serial_in | input | 1 | Serial frame input, idles high |
| latch_hi | input | 1 | Receiver enable; high selects asynchronous reception |
| dac_word | output | 16 | Holding register driving the converter |
| word_valid | output | 1 | One-clock strobe on each update of `dac_word` |
| frame_err | output | 1 | One-clock pulse when a stop bit reads low |

## Verification
Several kinds of wrong internal state show at the ports, each within one frame of roughly 288 clocks:
- A wrong cell counter moves the strobe away from edge 284, or samples the wrong cell, which shifts or mixes bits in `dac_word`.
- A wrong arming state either accepts a glitch or a line still held low as a frame, which produces an extra strobe or error, or misses the next real frame.
- A wrong holding path lets `dac_word` move without `word_valid`, or move on a bad stop bit.

The reference model runs in step with the receiver and compares all three outputs on every clock, so each of these faults is caught in the cycle where it first becomes visible.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

   typedef enum logic [1:0] {
      RX_WAIT_HIGH = 2'd0,
      RX_ARMED     = 2'd1,
      RX_RUN       = 2'd2
   } rx_state_e;

   function automatic int unsigned rx_stop_count(input int unsigned ovs,
                                                 input int unsigned bits);
      return (ovs / 2) + ovs * (bits + 1);
   endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          IDLE_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rx_line_sync: STAGES must be at least 2");
   end

   logic chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= IDLE_LVL;
            else        chain[0] <= din;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LVL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/rx_cell_timer.sv
module rx_cell_timer
   import async_rx_pkg::*;
#(
   parameter int unsigned OVS    = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic at_start,
   output logic at_data,
   output logic at_stop
);

   localparam int unsigned HALF   = OVS / 2;
   localparam int unsigned LOG_OV = $clog2(OVS);
   localparam int unsigned FIRST  = OVS + HALF;
   localparam int unsigned STOP   = rx_stop_count(OVS, DATA_W);
   localparam int unsigned CW     = $clog2(STOP + 1);

   if (OVS < 4 || (1 << LOG_OV) != OVS) begin : g_bad_ovs
      $error("rx_cell_timer: OVS must be a power of two, at least 4");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (!run)            cnt <= '0;
      else if (cnt != CW'(STOP)) cnt <= cnt + 1'b1;
   end

   assign at_start = run && (cnt == CW'(HALF));
   assign at_stop  = run && (cnt == CW'(STOP));
   assign at_data  = run && (cnt >= CW'(FIRST)) && (cnt < CW'(STOP)) &&
                     (cnt[LOG_OV-1:0] == LOG_OV'(HALF));

   // R8
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(STOP));

   // R8
   stop_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_stop |=> !run);

endmodule

// File: rtl/rx_word_shift.sv
module rx_word_shift #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              commit,
   output logic [DATA_W-1:0] word
);

   if (DATA_W < 2) begin : g_bad_width
      $error("rx_word_shift: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        shreg <= '0;
      else if (shift_en) shreg <= {shreg[DATA_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      word <= '0;
      else if (commit) word <= shreg;
   end

   // R3
   hold_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(word));

   // R2
   no_shift_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit && shift_en));

endmodule

// File: rtl/async_word_rx.sv
module async_word_rx
   import async_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              serial_in,
   input  logic              latch_hi,
   output logic [DATA_W-1:0] dac_word,
   output logic              word_valid,
   output logic              frame_err
);

   rx_state_e state;
   logic      line_s;
   logic      run;
   logic      at_start, at_data, at_stop;
   logic      shift_en, commit;

   rx_line_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (serial_in),
      .dout  (line_s)
   );

   assign run = (state == RX_RUN);

   rx_cell_timer #(
      .OVS    (OVS),
      .DATA_W (DATA_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .at_start (at_start),
      .at_data  (at_data),
      .at_stop  (at_stop)
   );

   assign shift_en = latch_hi && at_data;
   assign commit   = latch_hi && at_stop && line_s;

   rx_word_shift #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .bit_in   (line_s),
      .commit   (commit),
      .word     (dac_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_WAIT_HIGH;
         word_valid <= 1'b0;
         frame_err  <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         frame_err  <= 1'b0;
         if (!latch_hi) begin
            state <= RX_WAIT_HIGH;
         end else begin
            unique case (state)
               RX_WAIT_HIGH: if (line_s) state <= RX_ARMED;
               RX_ARMED:     if (!line_s) state <= RX_RUN;
               RX_RUN: begin
                  if (at_start && line_s) begin
                     state <= RX_ARMED;
                  end else if (at_stop) begin
                     state <= RX_WAIT_HIGH;
                     if (line_s) word_valid <= 1'b1;
                     else        frame_err  <= 1'b1;
                  end
               end
               default: state <= RX_WAIT_HIGH;
            endcase
         end
      end
   end

   // R3
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R3
   word_moves_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dac_word) |-> word_valid);

   // R4
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   // R4
   err_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> ($stable(dac_word) && !word_valid));

   // R7
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_hi |=> (!word_valid && !frame_err));

   // R6
   rearm_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_WAIT_HIGH && !line_s) |=> state != RX_RUN);

endmodule

// File: tb/tb_async_word_rx.sv
`timescale 1ns/1ps
module tb_async_word_rx;

   localparam int DW    = 16;
   localparam int OV    = 16;
   localparam int HALF  = OV / 2;
   localparam int FIRST = OV + HALF;
   localparam int STOPC = HALF + OV * (DW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          serial_in = 1'b1;
   logic          latch_hi = 1'b1;
   logic [DW-1:0] dac_word;
   logic          word_valid;
   logic          frame_err;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int n_valid = 0;
   int n_err = 0;
   int last_valid_cyc = -1;
   bit done = 0;

   async_word_rx #(.DATA_W(DW), .OVS(OV), .SYNC_STAGES(2)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .serial_in  (serial_in),
      .latch_hi   (latch_hi),
      .dac_word   (dac_word),
      .word_valid (word_valid),
      .frame_err  (frame_err)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // reference model state
   bit        m_sync [2];
   int        m_state;
   int        m_cnt;
   bit        m_bits [$];
   logic [DW-1:0] e_word;
   bit        e_valid, e_err;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sync[0] = 1'b1; m_sync[1] = 1'b1;
         m_state = 0; m_cnt = 0; m_bits.delete();
         e_word = '0; e_valid = 0; e_err = 0;
      end else begin
         bit s;
         s = m_sync[1];
         e_valid = 0; e_err = 0;
         if (!latch_hi) m_state = 0;
         else if (m_state == 0) begin
            if (s) m_state = 1;
         end else if (m_state == 1) begin
            if (!s) begin m_state = 2; m_cnt = 0; m_bits.delete(); end
         end else begin
            if (m_cnt == HALF && s) m_state = 1;
            else begin
               if (m_cnt >= FIRST && m_cnt < STOPC && ((m_cnt - FIRST) % OV) == 0)
                  m_bits.push_back(s);
               if (m_cnt == STOPC) begin
                  m_state = 0;
                  if (s) begin
                     logic [DW-1:0] w;
                     w = '0;
                     foreach (m_bits[i]) w = {w[DW-2:0], m_bits[i]};
                     e_word = w; e_valid = 1;
                  end else e_err = 1;
               end
               m_cnt++;
            end
         end
         m_sync[1] = m_sync[0];
         m_sync[0] = serial_in;
      end
   end

   always @(posedge clk) cyc++;

   // per-clock comparison with the model, plus event counters
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 word vs model", 32'(dac_word), 32'(e_word));
         chk("R3 strobe vs model", 32'(word_valid), 32'(e_valid));
         chk("R4 error vs model", 32'(frame_err), 32'(e_err));
         if (word_valid) begin n_valid++; last_valid_cyc = cyc; end
         if (frame_err) n_err++;
      end
   end

   int t_start;

   task automatic hold_line(input bit b, input int n);
      serial_in = b;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [DW-1:0] w, input bit stop_bit);
      t_start = cyc;
      hold_line(1'b0, OV);
      for (int i = DW - 1; i >= 0; i--) hold_line(w[i], OV);
      hold_line(stop_bit, OV);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset word", 32'(dac_word), 32'h0);
      chk("R1 reset strobe", 32'(word_valid), 32'h0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 word after reset", 32'(dac_word), 32'h0);
      chk("R1 error after reset", 32'(frame_err), 32'h0);

      // R2, R8: single frame, exact strobe timing
      send(16'hA5C3, 1'b1);
      hold_line(1'b1, 20);
      chk("R2 word A5C3", 32'(dac_word), 32'hA5C3);
      chk("R8 strobe edge", 32'(last_valid_cyc - t_start), 32'd284);

      // R2: back-to-back frames with distinct patterns
      send(16'h0000, 1'b1);
      send(16'hFFFF, 1'b1);
      send(16'h8001, 1'b1);
      hold_line(1'b1, 20);
      chk("R2 word 8001", 32'(dac_word), 32'h8001);
      chk("R3 strobe count", 32'(n_valid), 32'd4);

      // R4, R6: bad stop, line then held low
      send(16'h1234, 1'b0);
      hold_line(1'b0, 100);
      hold_line(1'b1, 40);
      chk("R4 word kept", 32'(dac_word), 32'h8001);
      chk("R4 error count", 32'(n_err), 32'd1);
      chk("R6 no frame while low", 32'(n_valid), 32'd4);

      // R5: short start glitch
      hold_line(1'b0, 4);
      hold_line(1'b1, 320);
      chk("R5 glitch no strobe", 32'(n_valid), 32'd4);
      chk("R5 glitch no error", 32'(n_err), 32'd1);
      send(16'h5A5A, 1'b1);
      hold_line(1'b1, 20);
      chk("R5 frame after glitch", 32'(dac_word), 32'h5A5A);

      // R7: receiver disabled
      latch_hi = 1'b0;
      send(16'h0F0F, 1'b1);
      send(16'h3333, 1'b0);
      hold_line(1'b1, 20);
      chk("R7 word unchanged", 32'(dac_word), 32'h5A5A);
      chk("R7 no strobe", 32'(n_valid), 32'd5);
      chk("R7 no error", 32'(n_err), 32'd1);
      latch_hi = 1'b1;
      hold_line(1'b1, 10);
      send(16'h7E81, 1'b1);
      hold_line(1'b1, 20);
      chk("R7 reenabled frame", 32'(dac_word), 32'h7E81);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule